// File: doc/BRIEF.md
# Time-Triggered Schedule Trigger Sequencer

This block steps through a small table of time triggers once per basic cycle of a time-triggered CAN network. Software loads the table while the node is held in configuration mode. Each entry holds four things: a kind, a message number, a 7-bit cycle code that says in which basic cycles the entry applies, and a 16-bit time mark in network time units. After configuration mode is left, a cycle-start pulse sends the walk back to entry 0. The sequencer then looks at one entry per clock. Once the running cycle time has reached an entry's time mark, the entry is consumed. If it passes all checks and its cycle code selects the current cycle count, the sequencer emits a one-clock event that carries the entry's kind and message number.

The table must be kept in ascending time-mark order, and an end-of-list entry stops the walk. Any entry that breaks the ordering rule, cannot be reached, or is malformed is consumed without producing an event and raises a sticky error flag. At each matrix-cycle boundary the block compares the number of transmit events it has emitted against an expected count.

Top module: `tsq_sequencer`

## Requirements
- R1: A write to the trigger table takes effect only while `cfg_mode` is 1. A write presented while `cfg_mode` is 0 leaves the stored entry unchanged. Entry encoding of `wr_data`: bits [31:29] kind, [28:23] message number, [22:16] cycle code, [15:0] time mark.
- R2: Kind codes are 0 end-of-list, 1 reference transmit, 2 transmit, 3 receive, 4 watch, 5 time mark, and 6/7 reserved.
  - Entries are consumed strictly in table order, at most one per clock. An entry is consumed only when `cycle_time` is greater than or equal to its time mark.
  - An accepted entry drives `trig_valid` high for one clock, with `trig_kind` and `trig_msg` set to the entry's fields. These outputs appear one clock after the consuming edge.
- R3: The highest set bit k of the cycle code selects a period of 2^k cycles. The entry applies when `cycle_cnt` mod 2^k equals the code's bits below k. Code 0000001 therefore applies in every cycle. A code of zero never applies. An entry that does not apply is consumed silently.
- R4: Walk start, end and restart:
  - A `cycle_start` pulse resets the walk to entry 0 and re-arms it, even in the middle of a walk. No event is produced on that clock.
  - Reaching an end-of-list entry stops the walk until the next `cycle_start`.
  - Consuming the last table slot also stops the walk.
- R5: An accepted reference-transmit entry also raises `ref_req` in the same clock as its event. A reference-transmit entry whose message number is not 1 sets `err_cfg` and produces no event.
- R6: An entry whose time mark is lower than that of the previously consumed entry in the same cycle sets `err_order` and produces no event.
- R7: Either of the following sets `err_cfg`, and the entry produces no event:
  - a non-reference entry whose time mark is below `ref_span` (unreachable behind the reference message);
  - an entry of reserved kind.
- R8: A matrix boundary is a `cycle_start` with `cycle_cnt` equal to 0.
  - At every matrix boundary after the first since configuration, `err_count` is set if the number of kind-2 events emitted since the previous boundary differs from `exp_tx`.
- R9: While `cfg_mode` is 1 the walk is halted and no events are produced. All three error flags read 0 one clock later. Outside configuration mode the error flags are sticky.
- R10: After reset every output is 0 and every table slot holds an end-of-list entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_mode | input | 1 | Configuration mode: enables table writes, halts the walk |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 4 | Table slot to write |
| wr_data | input | 32 | Entry: kind, message number, cycle code, time mark |
| cycle_start | input | 1 | Basic-cycle start pulse |
| cycle_time | input | 16 | Running cycle time |
| cycle_cnt | input | 6 | Current basic-cycle count |
| ref_span | input | 16 | First reachable time mark after the reference message |
| exp_tx | input | 11 | Expected transmit events per matrix cycle |
| trig_valid | output | 1 | Trigger event strobe |
| trig_kind | output | 3 | Kind of the event |
| trig_msg | output | 6 | Message number of the event |
| ref_req | output | 1 | Reference-message transmit request |
| err_order | output | 1 | Sticky ordering error |
| err_cfg | output | 1 | Sticky configuration error |
| err_count | output | 1 | Sticky transmit-count mismatch |

## Verification
The assertions rely on the following assumptions about the inputs:
- `cycle_start` is a single-clock pulse that is never issued together with `cfg_mode`.
- Table writes arrive only through the configuration path.

The stimulus keeps within these assumptions. It raises `cfg_mode` only between complete stimulus phases, always pulses `cycle_start` with `cycle_time` at 0, and then advances cycle time by one per clock, so the time marks are crossed in order.

A behavioural model in the bench tracks the pointer, the sticky flags and the transmit tally. It is compared with every output on every clock, and per-message event tallies confirm the period and offset selection.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int TM_W   = 16;
  localparam int MSG_W  = 6;
  localparam int CYC_W  = 6;
  localparam int CODE_W = CYC_W + 1;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_END   = 3'd0,
    K_REF   = 3'd1,
    K_TX    = 3'd2,
    K_RX    = 3'd3,
    K_WATCH = 3'd4,
    K_MARK  = 3'd5,
    K_RSV6  = 3'd6,
    K_RSV7  = 3'd7
  } kind_e;

  typedef struct packed {
    kind_e              kind;
    logic [MSG_W-1:0]   msg;
    logic [CODE_W-1:0]  code;
    logic [TM_W-1:0]    mark;
  } trig_t;

  localparam int ENTRY_W = $bits(trig_t);
endpackage

// File: rtl/tsq_trig_mem.sv
module tsq_trig_mem
  import tsq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mode,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  trig_t         wr_data,
  input  logic [AW-1:0] rd_addr,
  output trig_t         rd_data
);
  trig_t      slot_q [DEPTH];
  logic [DEPTH-1:0] wr_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign wr_hit[i] = wr_en & cfg_mode & (wr_addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[i] <= '0;
      end else if (wr_hit[i]) begin
        slot_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = slot_q[rd_addr];
  end
endmodule

// File: rtl/tsq_cycle_match.sv
module tsq_cycle_match
  import tsq_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [CYC_W-1:0]  cyc,
  output logic              hit
);
  logic [CODE_W-1:0] lead;
  logic [CODE_W-1:0] same;

  for (genvar k = 0; k < CODE_W; k++) begin : g_len
    localparam logic [CYC_W-1:0] MASK = CYC_W'((1 << k) - 1);
    assign lead[k] = code[k] & ~(|(code >> (k + 1)));
    assign same[k] = (((cyc ^ code[CYC_W-1:0]) & MASK) == '0);
  end

  assign hit = |(lead & same);
endmodule

// File: rtl/tsq_walker.sv
module tsq_walker
  import tsq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic              cycle_start,
  input  logic [TM_W-1:0]   cycle_time,
  input  logic [TM_W-1:0]   ref_span,
  input  trig_t             entry,
  input  logic              hit,
  output logic [AW-1:0]     ptr,
  output logic              tx_take,
  output logic              ev_valid,
  output logic [KIND_W-1:0] ev_kind,
  output logic [MSG_W-1:0]  ev_msg,
  output logic              ev_ref,
  output logic              err_order,
  output logic              err_cfg
);
  logic [AW-1:0]     ptr_q, ptr_n;
  logic              act_q, act_n;
  logic [TM_W-1:0]   prev_q, prev_n;
  logic              ord_q, ord_n;
  logic              cfe_q, cfe_n;
  logic              val_n, ref_n;
  logic [KIND_W-1:0] kind_q, kind_n;
  logic [MSG_W-1:0]  msg_q, msg_n;
  logic              val_q, ref_q;

  logic run, is_end, reached, step, bad_order, bad_cfg, take, last;

  always_comb begin
    run       = act_q & ~cfg_mode & ~cycle_start;
    is_end    = (entry.kind == K_END);
    reached   = (entry.mark <= cycle_time);
    step      = run & ~is_end & reached;
    last      = (ptr_q == AW'(DEPTH - 1));
    bad_order = (entry.mark < prev_q);
    bad_cfg   = (entry.kind == K_RSV6) | (entry.kind == K_RSV7)
              | ((entry.kind == K_REF) & (entry.msg != MSG_W'(1)))
              | ((entry.kind != K_REF) & (entry.mark < ref_span));
    take      = step & ~bad_order & ~bad_cfg & hit;
    tx_take   = take & (entry.kind == K_TX);
  end

  always_comb begin
    ptr_n  = ptr_q;
    act_n  = act_q;
    prev_n = prev_q;
    ord_n  = ord_q;
    cfe_n  = cfe_q;
    val_n  = take;
    ref_n  = take & (entry.kind == K_REF);
    kind_n = take ? KIND_W'(entry.kind) : '0;
    msg_n  = take ? entry.msg : '0;
    if (cfg_mode) begin
      ptr_n  = '0;
      act_n  = 1'b0;
      prev_n = '0;
      ord_n  = 1'b0;
      cfe_n  = 1'b0;
    end else if (cycle_start) begin
      ptr_n  = '0;
      act_n  = 1'b1;
      prev_n = '0;
    end else if (run & is_end) begin
      act_n  = 1'b0;
    end else if (step) begin
      ptr_n  = last ? ptr_q : ptr_q + 1'b1;
      act_n  = ~last;
      prev_n = entry.mark;
      ord_n  = ord_q | bad_order;
      cfe_n  = cfe_q | bad_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      act_q  <= 1'b0;
      prev_q <= '0;
      ord_q  <= 1'b0;
      cfe_q  <= 1'b0;
      val_q  <= 1'b0;
      ref_q  <= 1'b0;
      kind_q <= '0;
      msg_q  <= '0;
    end else begin
      ptr_q  <= ptr_n;
      act_q  <= act_n;
      prev_q <= prev_n;
      ord_q  <= ord_n;
      cfe_q  <= cfe_n;
      val_q  <= val_n;
      ref_q  <= ref_n;
      kind_q <= kind_n;
      msg_q  <= msg_n;
    end
  end

  assign ptr       = ptr_q;
  assign ev_valid  = val_q;
  assign ev_kind   = kind_q;
  assign ev_msg    = msg_q;
  assign ev_ref    = ref_q;
  assign err_order = ord_q;
  assign err_cfg   = cfe_q;
endmodule

// File: rtl/tsq_tx_budget.sv
module tsq_tx_budget
  import tsq_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_mode,
  input  logic             cycle_start,
  input  logic [CYC_W-1:0] cycle_cnt,
  input  logic             tx_take,
  input  logic [CNT_W-1:0] exp_tx,
  output logic             err_count
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             arm_q, arm_n;
  logic             err_q, err_n;
  logic             boundary;

  always_comb begin
    boundary = ~cfg_mode & cycle_start & (cycle_cnt == '0);
    cnt_n    = cnt_q;
    arm_n    = arm_q;
    err_n    = err_q;
    if (cfg_mode) begin
      cnt_n = '0;
      arm_n = 1'b0;
      err_n = 1'b0;
    end else if (boundary) begin
      err_n = err_q | (arm_q & (cnt_q != exp_tx));
      cnt_n = '0;
      arm_n = 1'b1;
    end else if (tx_take & ~(&cnt_q)) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      arm_q <= arm_n;
      err_q <= err_n;
    end
  end

  assign err_count = err_q;
endmodule

// File: rtl/tsq_sequencer.sv
module tsq_sequencer
  import tsq_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int AW      = $clog2(ENTRIES),
  parameter int CNT_W   = $clog2(ENTRIES * (1 << CYC_W) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_mode,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               cycle_start,
  input  logic [TM_W-1:0]    cycle_time,
  input  logic [CYC_W-1:0]   cycle_cnt,
  input  logic [TM_W-1:0]    ref_span,
  input  logic [CNT_W-1:0]   exp_tx,
  output logic               trig_valid,
  output logic [KIND_W-1:0]  trig_kind,
  output logic [MSG_W-1:0]   trig_msg,
  output logic               ref_req,
  output logic               err_order,
  output logic               err_cfg,
  output logic               err_count
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  trig_t         entry;
  logic [AW-1:0] ptr;
  logic          hit;
  logic          tx_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  tsq_trig_mem #(.DEPTH(ENTRIES), .AW(AW)) u_mem (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cfg_mode (cfg_mode),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (trig_t'(wr_data)),
    .rd_addr  (ptr),
    .rd_data  (entry)
  );

  tsq_cycle_match u_match (
    .code (entry.code),
    .cyc  (cycle_cnt),
    .hit  (hit)
  );

  tsq_walker #(.DEPTH(ENTRIES), .AW(AW)) u_walk (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cfg_mode    (cfg_mode),
    .cycle_start (cycle_start),
    .cycle_time  (cycle_time),
    .ref_span    (ref_span),
    .entry       (entry),
    .hit         (hit),
    .ptr         (ptr),
    .tx_take     (tx_take),
    .ev_valid    (trig_valid),
    .ev_kind     (trig_kind),
    .ev_msg      (trig_msg),
    .ev_ref      (ref_req),
    .err_order   (err_order),
    .err_cfg     (err_cfg)
  );

  tsq_tx_budget #(.CNT_W(CNT_W)) u_budget (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cfg_mode    (cfg_mode),
    .cycle_start (cycle_start),
    .cycle_cnt   (cycle_cnt),
    .tx_take     (tx_take),
    .exp_tx      (exp_tx),
    .err_count   (err_count)
  );
endmodule

// File: rtl/tsq_sequencer_chk.sv
module tsq_sequencer_chk
  import tsq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_mode,
  input logic              cycle_start,
  input logic              trig_valid,
  input logic [KIND_W-1:0] trig_kind,
  input logic [MSG_W-1:0]  trig_msg,
  input logic              ref_req,
  input logic              err_order,
  input logic              err_cfg,
  input logic              err_count
);
  p_kind_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> (trig_kind != 3'd0) && (trig_kind < 3'd6));

  p_start_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> !trig_valid);

  p_ref_msg_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_kind == 3'd1) |-> (trig_msg == 6'd1));

  p_req_has_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (trig_valid && trig_kind == 3'd1));

  p_event_has_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_kind == 3'd1) |-> ref_req);

  p_order_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_order && !cfg_mode) |=> err_order);

  p_cfg_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cfg && !cfg_mode) |=> err_cfg);

  p_count_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count && !cfg_mode) |=> err_count);

  p_cfg_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |=> !trig_valid);

  p_cfg_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |=> (!err_order && !err_cfg && !err_count));
endmodule

bind tsq_sequencer tsq_sequencer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_mode    (cfg_mode),
  .cycle_start (cycle_start),
  .trig_valid  (trig_valid),
  .trig_kind   (trig_kind),
  .trig_msg    (trig_msg),
  .ref_req     (ref_req),
  .err_order   (err_order),
  .err_cfg     (err_cfg),
  .err_count   (err_count)
);

// File: tb/tsq_sequencer_tb.sv
module tsq_sequencer_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_mode;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic        cycle_start;
  logic [15:0] cycle_time;
  logic [5:0]  cycle_cnt;
  logic [15:0] ref_span;
  logic [10:0] exp_tx;
  logic        trig_valid;
  logic [2:0]  trig_kind;
  logic [5:0]  trig_msg;
  logic        ref_req;
  logic        err_order;
  logic        err_cfg;
  logic        err_count;

  int tests = 0;
  int fails = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tsq_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cycle_start(cycle_start),
    .cycle_time(cycle_time), .cycle_cnt(cycle_cnt), .ref_span(ref_span),
    .exp_tx(exp_tx), .trig_valid(trig_valid), .trig_kind(trig_kind),
    .trig_msg(trig_msg), .ref_req(ref_req), .err_order(err_order),
    .err_cfg(err_cfg), .err_count(err_count)
  );

  // behavioural reference model
  logic [31:0] m_tab [N];
  int  m_ptr, m_prev, m_tx;
  bit  m_act, m_arm;
  bit  e_val, e_ref, e_ord, e_cfg, e_cnt;
  int  e_kind, e_msg;
  int  seen [64];
  int  refs;

  function automatic bit applies(int code, int cnt);
    int k = -1;
    for (int b = 0; b < 7; b++) if (code[b]) k = b;
    if (k < 0) return 1'b0;
    return (cnt % (1 << k)) == (code % (1 << k));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_tab[i] <= '0;
      m_ptr <= 0; m_prev <= 0; m_tx <= 0; m_act <= 0; m_arm <= 0;
      e_val <= 0; e_ref <= 0; e_ord <= 0; e_cfg <= 0; e_cnt <= 0;
      e_kind <= 0; e_msg <= 0;
    end else begin
      e_val <= 0; e_ref <= 0; e_kind <= 0; e_msg <= 0;
      if (cfg_mode) begin
        if (wr_en) m_tab[wr_addr] <= wr_data;
        m_act <= 0; m_ptr <= 0; m_prev <= 0; m_tx <= 0; m_arm <= 0;
        e_ord <= 0; e_cfg <= 0; e_cnt <= 0;
      end else if (cycle_start) begin
        m_act <= 1; m_ptr <= 0; m_prev <= 0;
        if (cycle_cnt == 0) begin
          if (m_arm && m_tx != exp_tx) e_cnt <= 1;
          m_tx <= 0; m_arm <= 1;
        end
      end else if (m_act) begin
        int kind, msg, code, mark;
        bit bo, bc;
        kind = m_tab[m_ptr][31:29];
        msg  = m_tab[m_ptr][28:23];
        code = m_tab[m_ptr][22:16];
        mark = m_tab[m_ptr][15:0];
        if (kind == 0) begin
          m_act <= 0;
        end else if (mark <= cycle_time) begin
          bo = mark < m_prev;
          bc = (kind >= 6) || (kind == 1 && msg != 1) || (kind != 1 && mark < ref_span);
          if (bo) e_ord <= 1;
          if (bc) e_cfg <= 1;
          m_prev <= mark;
          if (m_ptr == N - 1) m_act <= 0; else m_ptr <= m_ptr + 1;
          if (!bo && !bc && applies(code, cycle_cnt)) begin
            e_val <= 1; e_kind <= kind; e_msg <= msg; e_ref <= (kind == 1);
            if (kind == 2) m_tx <= m_tx + 1;
          end
        end
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R2 trig_valid", trig_valid, e_val);
      chk("R2 trig_kind", trig_kind, e_kind);
      chk("R2 trig_msg", trig_msg, e_msg);
      chk("R5 ref_req", ref_req, e_ref);
      chk("R6 err_order", err_order, e_ord);
      chk("R7 err_cfg", err_cfg, e_cfg);
      chk("R8 err_count", err_count, e_cnt);
      if (trig_valid) seen[trig_msg]++;
      if (ref_req) refs++;
    end
  end

  function automatic logic [31:0] ent(int kind, int msg, int code, int mark);
    return {kind[2:0], msg[5:0], code[6:0], mark[15:0]};
  endfunction

  task automatic put(int addr, logic [31:0] d);
    wr_en = 1; wr_addr = addr[3:0]; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run_cycle(int cnt, int len);
    cycle_start = 1; cycle_cnt = cnt[5:0]; cycle_time = 0;
    @(negedge clk);
    cycle_start = 0;
    for (int t = 1; t <= len; t++) begin
      cycle_time = t[15:0];
      @(negedge clk);
    end
  endtask

  task automatic clear_tally();
    for (int i = 0; i < 64; i++) seen[i] = 0;
    refs = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_mode = 1; wr_en = 0; wr_addr = 0; wr_data = 0;
    cycle_start = 0; cycle_time = 0; cycle_cnt = 0; ref_span = 8; exp_tx = 6;
    clear_tally();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_on = 1;
    // R10: reset state
    chk("R10 trig_valid", trig_valid, 0);
    chk("R10 ref_req", ref_req, 0);
    chk("R10 errors", {err_order, err_cfg, err_count}, 0);

    // table A
    put(0, ent(2, 3, 7'b0000001, 10));
    put(1, ent(3, 4, 7'b0000010, 20));
    put(2, ent(2, 5, 7'b0000011, 30));
    put(3, ent(5, 6, 7'b1000101, 40));
    put(4, ent(3, 7, 7'b0010110, 45));
    put(5, ent(1, 1, 7'b0000001, 60));
    put(6, ent(0, 0, 0, 0));
    put(7, ent(2, 9, 7'b0000001, 70));
    cfg_mode = 0;
    @(negedge clk);
    put(0, ent(2, 12, 7'b0000001, 10)); // outside configuration: ignored
    clear_tally();
    run_cycle(0, 80); run_cycle(1, 80); run_cycle(2, 80); run_cycle(3, 80);
    run_cycle(0, 80); run_cycle(5, 80); run_cycle(22, 80);
    chk("R8 no mismatch after matching matrix", err_count, 0);
    run_cycle(0, 2);
    chk("R8 mismatch flagged", err_count, 1);
    chk("R1 ignored write kept msg3", seen[3], 7);
    chk("R1 ignored write msg12", seen[12], 0);
    chk("R3 every-cycle-2 offset0", seen[4], 4);
    chk("R3 every-cycle-2 offset1", seen[5], 3);
    chk("R3 period64 offset5", seen[6], 1);
    chk("R3 period16 offset6", seen[7], 1);
    chk("R5 reference requests", refs, 7);
    chk("R4 entry after end-of-list", seen[9], 0);

    // table B: error cases
    cfg_mode = 1;
    @(negedge clk); @(negedge clk);
    chk("R9 errors cleared in cfg", {err_order, err_cfg, err_count}, 0);
    put(0, ent(3, 14, 7'b0000001, 5));
    put(1, ent(2, 10, 7'b0000001, 20));
    put(2, ent(2, 11, 7'b0000001, 15));
    put(3, ent(3, 12, 7'b0000001, 25));
    put(4, ent(1, 2, 7'b0000001, 30));
    put(5, ent(7, 13, 7'b0000001, 35));
    for (int i = 6; i < N; i++) put(i, ent(2, 15, 7'b0000001, 34 + i));
    cfg_mode = 0;
    @(negedge clk);
    clear_tally();
    run_cycle(1, 80);
    chk("R7 unreachable mark no event", seen[14], 0);
    chk("R6 out-of-order no event", seen[11], 0);
    chk("R2 ordered entry fires", seen[10], 1);
    chk("R5 bad reference no request", refs, 0);
    chk("R7 reserved kind no event", seen[13], 0);
    chk("R4 walk to last slot", seen[15], 10);
    chk("R6 flag", err_order, 1);
    chk("R7 flag", err_cfg, 1);

    clear_tally();
    run_cycle(3, 22);
    run_cycle(3, 80);
    chk("R4 restart mid-walk", seen[10], 2);
    chk("R4 restart reaches later entry", seen[12], 1);
    chk("R6 sticky outside cfg", err_order, 1);
    cfg_mode = 1;
    @(negedge clk); @(negedge clk);
    chk("R9 cfg clears", {err_order, err_cfg}, 0);
    chk("R9 no events in cfg", trig_valid, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule